// File: doc/BRIEF.md
# Work-Queue Doorbell and Done-Bit Completion Unit

This unit sits between a host that posts work and a protocol engine that moves the data. Every virtual channel has two doorbells held in registers inside the unit: one for its send queue and one for its receive queue. The host writes these doorbells directly. The unit polls its own doorbells and never polls host memory. When it finds a doorbell set, it asks a DMA read port for that queue's next descriptor. It keeps the returned descriptor and shows it to the protocol engine until the engine reports that the transfer has finished.

Completion is reported in one way only. The unit writes the descriptor's status field back to host memory with the done bit set. No completion-queue entry is written, so a finished transaction costs no further DMA. Only one descriptor is in flight at a time. A doorbell write that arrives while its queue is already pending or in flight is counted, so that no post is lost. Each counted post becomes another fetch once the current descriptor of that queue has been released.

A queue is called a slot and is identified by the pair (VI, direction). Its slot number is VI*2+direction, where direction 0 is send and 1 is receive. The number of VIs is a parameter that may be set as high as 1024.

Top module: `vi_doorbell_unit`

## Requirements
- R1: After reset no read request, descriptor or write-back request is valid.
- R2: A doorbell write to an idle slot leads to one DMA read request carrying that slot's VI and direction (0 send, 1 receive). The request stays valid until it is accepted by `rdReqReady`.
- R3: When more than one slot is pending, the slots are served in round-robin order of slot number (VI*2+direction). The search starts just after the slot served last and wraps from the highest slot to slot 0.
- R4: A slot's doorbell is cleared when its read request is accepted. A single post therefore produces exactly one fetch.
- R5: The read response data is presented on `descData` with `descValid`, together with its VI and direction. It is held unchanged until the matching completion arrives.
- R6: A completion naming a different VI or a different direction from the held descriptor is ignored. The descriptor stays presented and no write-back is issued.
- R7: A completion that matches the held descriptor starts a write-back request in the next cycle. The request carries the held VI and direction, and its status word is bits 15:0 of the descriptor with bit 15 (the done bit) set. The slot is released when `wrRspValid` acknowledges the write.
- R8: A doorbell write to a slot that is already pending or in flight increments that slot's post count. Each counted post makes the slot pending again after a release, and the slot still takes its round-robin turn with the other slots.
- R9: The post count is 4 bits wide and saturates at 15. Further posts to a saturated slot are dropped.
- R10: At most one of read request, descriptor presentation and write-back is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host doorbell write strobe |
| hostWrVi | input | VI_W | VI addressed by the doorbell write |
| hostWrDir | input | 1 | Direction of the doorbell write (0 send, 1 receive) |
| rdReqValid | output | 1 | Descriptor fetch request valid |
| rdReqReady | input | 1 | Fetch request accepted |
| rdReqVi | output | VI_W | VI of the descriptor to fetch |
| rdReqDir | output | 1 | Direction of the descriptor to fetch |
| rdRspValid | input | 1 | Fetched descriptor returned |
| rdRspData | input | DESC_W | Fetched descriptor contents |
| descValid | output | 1 | Descriptor presented to the protocol engine |
| descVi | output | VI_W | VI of the presented descriptor |
| descDir | output | 1 | Direction of the presented descriptor |
| descData | output | DESC_W | Presented descriptor |
| cplValid | input | 1 | Transfer completion report from the protocol engine |
| cplVi | input | VI_W | VI named by the completion |
| cplDir | input | 1 | Direction named by the completion |
| wrReqValid | output | 1 | Status write-back request valid |
| wrReqReady | input | 1 | Write-back request accepted |
| wrReqVi | output | VI_W | VI of the write-back |
| wrReqDir | output | 1 | Direction of the write-back |
| wrReqStatus | output | STAT_W | Status field with the done bit set |
| wrRspValid | input | 1 | Write-back acknowledged |

## Verification
The bound checker watches the handshake discipline on every cycle:
- a held read request is never withdrawn;
- a write-back appears only right after a completion that names the same VI and direction;
- the write-back status equals the held status with the done bit set;
- a presented descriptor never changes or drops while no matching completion arrives;
- only one of the three phases is ever active.

The bench's scoreboard covers what needs the history of several posts. It checks the round-robin order across slots and the wrap-around. It checks that one post gives exactly one fetch. It checks that counted posts are replayed in turn with the other slots, and that the count stops at fifteen replays.

// File: rtl/vi_doorbell_pkg.sv
package vi_doorbell_pkg;

  typedef enum logic [2:0] {
    ST_SCAN,
    ST_FETCH,
    ST_WAITRSP,
    ST_HOLD,
    ST_WBACK,
    ST_WACK
  } engState_t;

  typedef struct packed {
    logic doLatch;    // capture the picked slot as current
    logic doIssue;    // fetch accepted: clear doorbell, mark in flight
    logic doCapture;  // store the returned descriptor
    logic doRelease;  // write-back acknowledged: free the slot
  } ctlStrobe_t;

endpackage

// File: rtl/vi_doorbell_datapath.sv
module vi_doorbell_datapath
  import vi_doorbell_pkg::*;
#(
  parameter int NUM_VI = 8,
  parameter int VI_W   = $clog2(NUM_VI),
  parameter int DESC_W = 64,
  parameter int STAT_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic              hostWrEn,
  input  logic [VI_W-1:0]   hostWrVi,
  input  logic              hostWrDir,
  input  logic [DESC_W-1:0] rdRspData,
  input  logic              cplValid,
  input  logic [VI_W-1:0]   cplVi,
  input  logic              cplDir,
  output logic              pickValid,
  output logic              cplMatch,
  output logic [VI_W-1:0]   curVi,
  output logic              curDir,
  output logic [DESC_W-1:0] descData,
  output logic [STAT_W-1:0] wrStatus
);

  localparam int NSLOT  = 2 * NUM_VI;
  localparam int SLOT_W = VI_W + 1;
  localparam logic [CNT_W-1:0]  CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [STAT_W-1:0] DONE_MASK = STAT_W'(1) << (STAT_W - 1);

  logic             pend [NSLOT];
  logic             busy [NSLOT];
  logic [CNT_W-1:0] cnt  [NSLOT];

  logic [SLOT_W-1:0] curSlot;
  logic [SLOT_W-1:0] pickIdx;
  logic [SLOT_W-1:0] hostIdx;
  logic [DESC_W-1:0] descReg;

  assign hostIdx = {hostWrVi, hostWrDir};

  // Per-slot doorbell, in-flight flag and post counter.
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic             hit, grant, rel, pNx, bNx;
    logic [CNT_W-1:0] cNx;

    always_comb begin
      hit   = hostWrEn && (hostIdx == SLOT_W'(s));
      grant = stb.doIssue && (curSlot == SLOT_W'(s));
      rel   = stb.doRelease && (curSlot == SLOT_W'(s));
      pNx   = pend[s];
      bNx   = busy[s];
      cNx   = cnt[s];
      if (grant) begin
        pNx = 1'b0;
        bNx = 1'b1;
      end
      if (rel) begin
        bNx = 1'b0;
        if (cnt[s] != '0) begin
          cNx = cnt[s] - CNT_W'(1);
          pNx = 1'b1;
        end
      end
      if (hit) begin
        if (pNx || bNx) begin
          if (cNx != CNT_MAX) cNx = cNx + CNT_W'(1);
        end else begin
          pNx = 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pend[s] <= 1'b0;
        busy[s] <= 1'b0;
        cnt[s]  <= '0;
      end else begin
        pend[s] <= pNx;
        busy[s] <= bNx;
        cnt[s]  <= cNx;
      end
    end
  end

  // Round-robin pick: nearest pending slot after the current one wins.
  always_comb begin
    pickValid = 1'b0;
    pickIdx   = '0;
    for (int k = NSLOT; k >= 1; k--) begin
      int idx;
      idx = (int'(curSlot) + k) % NSLOT;
      if (pend[idx]) begin
        pickValid = 1'b1;
        pickIdx   = SLOT_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSlot <= SLOT_W'(NSLOT - 1);
      descReg <= '0;
    end else begin
      if (stb.doLatch)   curSlot <= pickIdx;
      if (stb.doCapture) descReg <= rdRspData;
    end
  end

  assign curVi    = curSlot[SLOT_W-1:1];
  assign curDir   = curSlot[0];
  assign cplMatch = cplValid && ({cplVi, cplDir} == curSlot);
  assign descData = descReg;
  assign wrStatus = descReg[STAT_W-1:0] | DONE_MASK;

endmodule

// File: rtl/vi_doorbell_control.sv
module vi_doorbell_control
  import vi_doorbell_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pickValid,
  input  logic       rdReqReady,
  input  logic       rdRspValid,
  input  logic       cplMatch,
  input  logic       wrReqReady,
  input  logic       wrRspValid,
  output ctlStrobe_t stb,
  output logic       rdReqValid,
  output logic       descValid,
  output logic       wrReqValid
);

  engState_t state, stateNx;

  always_comb begin
    stateNx = state;
    stb     = '0;
    unique case (state)
      ST_SCAN: if (pickValid) begin
        stb.doLatch = 1'b1;
        stateNx     = ST_FETCH;
      end
      ST_FETCH: if (rdReqReady) begin
        stb.doIssue = 1'b1;
        stateNx     = ST_WAITRSP;
      end
      ST_WAITRSP: if (rdRspValid) begin
        stb.doCapture = 1'b1;
        stateNx       = ST_HOLD;
      end
      ST_HOLD: if (cplMatch) stateNx = ST_WBACK;
      ST_WBACK: if (wrReqReady) stateNx = ST_WACK;
      ST_WACK: if (wrRspValid) begin
        stb.doRelease = 1'b1;
        stateNx       = ST_SCAN;
      end
      default: stateNx = ST_SCAN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_SCAN;
    else       state <= stateNx;
  end

  assign rdReqValid = (state == ST_FETCH);
  assign descValid  = (state == ST_HOLD);
  assign wrReqValid = (state == ST_WBACK);

endmodule

// File: rtl/vi_doorbell_unit.sv
module vi_doorbell_unit
  import vi_doorbell_pkg::*;
#(
  parameter int NUM_VI = 8,
  parameter int VI_W   = $clog2(NUM_VI),
  parameter int DESC_W = 64,
  parameter int STAT_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [VI_W-1:0]   hostWrVi,
  input  logic              hostWrDir,
  output logic              rdReqValid,
  input  logic              rdReqReady,
  output logic [VI_W-1:0]   rdReqVi,
  output logic              rdReqDir,
  input  logic              rdRspValid,
  input  logic [DESC_W-1:0] rdRspData,
  output logic              descValid,
  output logic [VI_W-1:0]   descVi,
  output logic              descDir,
  output logic [DESC_W-1:0] descData,
  input  logic              cplValid,
  input  logic [VI_W-1:0]   cplVi,
  input  logic              cplDir,
  output logic              wrReqValid,
  input  logic              wrReqReady,
  output logic [VI_W-1:0]   wrReqVi,
  output logic              wrReqDir,
  output logic [STAT_W-1:0] wrReqStatus,
  input  logic              wrRspValid
);

  ctlStrobe_t      stb;
  logic            pickValid, cplMatch;
  logic [VI_W-1:0] curVi;
  logic            curDir;

  vi_doorbell_control u_ctl (
    .clk(clk), .rstN(rstN), .pickValid(pickValid), .rdReqReady(rdReqReady),
    .rdRspValid(rdRspValid), .cplMatch(cplMatch), .wrReqReady(wrReqReady),
    .wrRspValid(wrRspValid), .stb(stb), .rdReqValid(rdReqValid),
    .descValid(descValid), .wrReqValid(wrReqValid)
  );

  vi_doorbell_datapath #(
    .NUM_VI(NUM_VI), .VI_W(VI_W), .DESC_W(DESC_W), .STAT_W(STAT_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .hostWrEn(hostWrEn), .hostWrVi(hostWrVi),
    .hostWrDir(hostWrDir), .rdRspData(rdRspData), .cplValid(cplValid),
    .cplVi(cplVi), .cplDir(cplDir), .pickValid(pickValid), .cplMatch(cplMatch),
    .curVi(curVi), .curDir(curDir), .descData(descData), .wrStatus(wrReqStatus)
  );

  assign rdReqVi  = curVi;
  assign rdReqDir = curDir;
  assign descVi   = curVi;
  assign descDir  = curDir;
  assign wrReqVi  = curVi;
  assign wrReqDir = curDir;

endmodule

// File: rtl/vi_doorbell_unit_chk.sv
module vi_doorbell_unit_chk #(
  parameter int VI_W   = 3,
  parameter int DESC_W = 64,
  parameter int STAT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdReqValid,
  input logic              rdReqReady,
  input logic [VI_W-1:0]   rdReqVi,
  input logic              rdReqDir,
  input logic              rdRspValid,
  input logic              descValid,
  input logic [VI_W-1:0]   descVi,
  input logic              descDir,
  input logic [DESC_W-1:0] descData,
  input logic              cplValid,
  input logic [VI_W-1:0]   cplVi,
  input logic              cplDir,
  input logic              wrReqValid,
  input logic [VI_W-1:0]   wrReqVi,
  input logic              wrReqDir,
  input logic [STAT_W-1:0] wrReqStatus
);

  localparam logic [STAT_W-1:0] DONE_MASK = STAT_W'(1) << (STAT_W - 1);

  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdReqValid && !rdReqReady |=> rdReqValid && $stable(rdReqVi) && $stable(rdReqDir));

  assert_desc_after_rsp_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(descValid) |-> $past(rdRspValid));

  assert_desc_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    descValid && !(cplValid && cplVi == descVi && cplDir == descDir)
      |=> descValid && $stable(descData));

  assert_wb_after_cpl_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrReqValid) |-> $past(cplValid) && $past(cplVi) == wrReqVi
                          && $past(cplDir) == wrReqDir);

  assert_done_bit_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrReqValid) |-> wrReqStatus == ($past(descData[STAT_W-1:0]) | DONE_MASK));

  assert_one_phase_R10: assert property (@(posedge clk) disable iff (!rstN)
    $countones({rdReqValid, descValid, wrReqValid}) <= 1);

endmodule

bind vi_doorbell_unit vi_doorbell_unit_chk #(
  .VI_W(VI_W), .DESC_W(DESC_W), .STAT_W(STAT_W)
) u_chk (.*);

// File: tb/vi_doorbell_unit_test.sv
`timescale 1ns/1ps
module vi_doorbell_unit_test;

  localparam int VI_W = 3;

  logic clk = 1'b0;
  logic rstN;
  logic hostWrEn;
  logic [VI_W-1:0] hostWrVi;
  logic hostWrDir;
  logic rdReqValid, rdReqReady, rdReqDir, rdRspValid;
  logic [VI_W-1:0] rdReqVi;
  logic [63:0] rdRspData;
  logic descValid, descDir;
  logic [VI_W-1:0] descVi;
  logic [63:0] descData;
  logic cplValid, cplDir;
  logic [VI_W-1:0] cplVi;
  logic wrReqValid, wrReqReady, wrReqDir, wrRspValid;
  logic [VI_W-1:0] wrReqVi;
  logic [15:0] wrReqStatus;

  always #5 clk = ~clk;

  vi_doorbell_unit uut (.*);

  int nVec = 0;
  int nBad = 0;
  int exp[$];
  bit hold = 0;
  bit injReq = 0;
  logic [VI_W-1:0] injVi;
  logic injDir;

  function automatic logic [63:0] descOf(input int s);
    return {32'hC0DE_0000 | 32'(s), 16'h5A00 | 16'(s), 16'h0100 + 16'(s)};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // DMA / protocol-engine model and scoreboard monitor
  initial begin
    int curS = 0;
    bit rspDue = 0, ackDue = 0, descSeen = 0, cplSent = 0;
    rdReqReady = 1; wrReqReady = 1;
    rdRspValid = 0; rdRspData = '0; wrRspValid = 0;
    cplValid = 0; cplVi = '0; cplDir = 0;
    forever begin
      @(negedge clk);
      rdRspValid = 0; cplValid = 0; wrRspValid = 0;
      if (!rstN) continue;
      if (rspDue) begin rdRspValid = 1; rdRspData = descOf(curS); rspDue = 0; end
      if (ackDue) begin wrRspValid = 1; ackDue = 0; end
      if (rdReqValid) begin
        int slot;
        slot = int'(rdReqVi) * 2 + int'(rdReqDir);
        if (exp.size() == 0) check(0, "R4 unexpected fetch", slot, -1);
        else begin
          int e;
          e = exp.pop_front();
          check(slot == e, "R3 fetch order", slot, e);
        end
        curS = slot; rspDue = 1; descSeen = 0; cplSent = 0;
      end
      if (descValid && !descSeen) begin
        descSeen = 1;
        check(descData == descOf(curS), "R5 descriptor data", descData, descOf(curS));
        check(int'(descVi) * 2 + int'(descDir) == curS, "R5 descriptor slot",
              int'(descVi) * 2 + int'(descDir), curS);
      end
      if (injReq) begin
        cplValid = 1; cplVi = injVi; cplDir = injDir; injReq = 0;
      end else if (descValid && !hold && !cplSent) begin
        cplValid = 1; cplVi = VI_W'(curS >> 1); cplDir = curS[0]; cplSent = 1;
      end
      if (wrReqValid) begin
        logic [63:0] d;
        d = descOf(curS);
        check(wrReqStatus == (d[15:0] | 16'h8000), "R7 done-bit status", wrReqStatus,
              d[15:0] | 16'h8000);
        check(int'(wrReqVi) * 2 + int'(wrReqDir) == curS, "R7 write-back slot",
              int'(wrReqVi) * 2 + int'(wrReqDir), curS);
        ackDue = 1;
      end
    end
  end

  task automatic post(input int vi, input bit dir);
    @(posedge clk); #1;
    hostWrEn = 1; hostWrVi = VI_W'(vi); hostWrDir = dir;
    @(posedge clk); #1;
    hostWrEn = 0;
  endtask

  task automatic waitDesc();
    for (int i = 0; i < 200 && !descValid; i++) @(negedge clk);
  endtask

  task automatic setHold(input bit h);
    @(posedge clk); #1; hold = h;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 2000 && exp.size() != 0; i++) @(negedge clk);
    repeat (12) @(negedge clk);
    check(exp.size() == 0, req, exp.size(), 0);
    check(!rdReqValid && !descValid && !wrReqValid, req,
          {rdReqValid, descValid, wrReqValid}, 0);
  endtask

  task automatic inject(input int vi, input bit dir);
    @(posedge clk); #1;
    injVi = VI_W'(vi); injDir = dir; injReq = 1;
    repeat (3) @(negedge clk);
    check(descValid && !wrReqValid, "R6 foreign completion ignored",
          {descValid, wrReqValid}, 2'b10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    rstN = 0; hostWrEn = 0; hostWrVi = '0; hostWrDir = 0;
    repeat (4) @(negedge clk);
    check(!rdReqValid && !descValid && !wrReqValid, "R1 in reset",
          {rdReqValid, descValid, wrReqValid}, 0);
    rstN = 1;
    @(negedge clk);
    check(!rdReqValid && !descValid && !wrReqValid, "R1 after reset",
          {rdReqValid, descValid, wrReqValid}, 0);

    // R2/R4: single post to VI3 send (slot 6), exactly one fetch
    exp.push_back(6);
    post(3, 0);
    drain("R4 single post single fetch");

    // R3: round-robin with wrap; posts written out of slot order
    setHold(1);
    exp.push_back(0);
    post(0, 0);
    waitDesc();
    exp.push_back(3); exp.push_back(4); exp.push_back(10);
    post(2, 0); post(1, 1); post(5, 0);
    setHold(0);
    drain("R3 round-robin drain");

    // R6: completions with wrong direction and wrong VI are ignored
    setHold(1);
    exp.push_back(13);
    post(6, 1);
    waitDesc();
    inject(6, 0);
    inject(5, 1);
    check(descData == descOf(13), "R6 descriptor unchanged", descData, descOf(13));
    setHold(0);
    drain("R6 drain");

    // R8: counted posts replay and take turns with another slot
    setHold(1);
    exp.push_back(4);
    post(2, 0);
    waitDesc();
    post(2, 0); post(2, 0); post(4, 1);
    exp.push_back(9); exp.push_back(4); exp.push_back(4);
    setHold(0);
    drain("R8 counted replays");

    // R9: 20 extra posts saturate at 15 replays
    setHold(1);
    exp.push_back(15);
    post(7, 1);
    waitDesc();
    repeat (20) post(7, 1);
    for (int i = 0; i < 15; i++) exp.push_back(15);
    setHold(0);
    drain("R9 saturation");

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule